// File: doc/BRIEF.md
# Single-Channel Memory Copy DMA Engine

This block is one DMA channel that copies a number of data units from a source address to a destination address on a shared bus. Software sets up a source address, a destination address and a unit count through a small register port, selects the unit size and an address mode for each side in a control word, and then sets the start bit. The channel asks for the bus and reads each unit. It writes the unit back out and moves both addresses. When the count reaches zero it reports completion and can raise an interrupt.

A unit is a byte, a 16-bit word, a 32-bit longword or a 16-byte block. A 16-byte block is carried as four longword read/write pairs at offsets 0, 4, 8 and 12. After each block both addresses advance by 16, whatever address mode is selected. In cycle-steal mode the channel drops its bus request after every unit so that other masters can take the bus. In burst mode it keeps the bus until the whole transfer is finished. A misaligned start address stops the channel before any bus access and sets an error flag.

Top module: `dma_chan`

## Requirements
- R1: After a synchronous reset all four registers read as zero, and `m_req`, `m_stb` and `irq` are low. Register select 0 is source, 1 destination, 2 count, 3 control. `reg_rdata` shows the selected register one clock after `reg_sel` is applied, zero-extended to 32 bits.
- R2: Control word bits: 0 start, 1 done, 2 error, 3 interrupt enable, [5:4] source mode, [7:6] destination mode, [9:8] unit size, 10 burst. A 1 written to bit 1 or bit 2 clears that flag. The start bit is taken only when done and error were both clear before the write; otherwise it stays 0 and no bus request appears.
- R3: Mode encodings are 00 fixed, 01 increment, 10 decrement and 11 fixed. Size encodings are 00 byte, 01 word, 10 longword and 11 16-byte. For byte, word and longword units each address moves by 1, 2 or 4 in the direction its mode gives, wrapping modulo 2^AW.
- R4: A 16-byte unit is four longword read/write pairs at offsets 0, 4, 8 and 12 from the current addresses. Afterwards both addresses advance by +16 regardless of their mode fields.
- R5: The count drops by one per completed unit. The transfer ends, with done set and start cleared, when it reaches zero. A start with count zero sets done at once and makes no bus access.
- R6: A start with an address misaligned for the unit size sets error, clears start and makes no bus access. The misaligned cases are an odd address for words, a nonzero low two bits for longwords and a nonzero low four bits for 16-byte units. Addresses and count are left unchanged.
- R7: `irq` is high while both the done flag and the interrupt enable bit are set.
- R8: In cycle-steal mode `m_req` falls after every unit. In burst mode it stays high from the first access until the last unit, so each transfer shows exactly one release.
- R9: `m_stb` is raised only while `m_gnt` is high. Each beat reads at the source side and then writes the read data unchanged to the destination side.
- R10: While a transfer is running, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq | output | 1 | Completion interrupt |
| m_req | output | 1 | Bus request |
| m_gnt | input | 1 | Bus grant |
| m_stb | output | 1 | Bus access strobe, held until acknowledged |
| m_we | output | 1 | Bus access is a write |
| m_addr | output | AW | Bus byte address |
| m_size | output | 2 | Access size code (same encoding as the unit size) |
| m_wdata | output | 32 | Bus write data |
| m_rdata | input | 32 | Bus read data |
| m_ack | input | 1 | Bus access acknowledge |

## Verification
The bench builds the channel with a 16-bit address and an 8-bit count. The narrow address lets a decrementing destination cross zero within a few units, which checks wrap-around next to increment, fixed and the forced +16 step of 16-byte units. The small count keeps every table entry short, so each entry can cover a different mix of unit size, address mode and release mode. Every written address and data word is compared with what the bench expects.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_HOLD = 2'd3} amode_t;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_QUAD = 2'd3} usize_t;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_REL} st_t;

  localparam int CB_GO    = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_ERR   = 2;
  localparam int CB_IE    = 3;
  localparam int CB_SM    = 4;
  localparam int CB_DM    = 6;
  localparam int CB_SZ    = 8;
  localparam int CB_BURST = 10;

  typedef struct packed {
    logic   burst;
    usize_t sz;
    amode_t dm;
    amode_t sm;
    logic   ie;
  } cfg_t;

endpackage

// File: rtl/dma_step.sv
module dma_step
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  amode_t        mode,
  input  usize_t        sz,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] stp;

  always_comb begin
    stp = AW'(1) << sz;
    if (sz == SZ_QUAD) begin
      nxt = addr + AW'(16);
    end else begin
      case (mode)
        AM_INC:  nxt = addr + stp;
        AM_DEC:  nxt = addr - stp;
        default: nxt = addr;
      endcase
    end
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          upd,
  input  logic [AW-1:0] src_nxt,
  input  logic [AW-1:0] dst_nxt,
  input  logic          fin,
  input  logic          fault,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          go,
  output logic          done,
  output logic          err,
  output cfg_t          cfg,
  output logic          irq
);
  logic [31:0] ctrl_rd;

  assign ctrl_rd = {21'b0, cfg.burst, cfg.sz, cfg.dm, cfg.sm, cfg.ie, err, done, go};

  always_ff @(posedge clk) begin
    if (rst) begin
      src       <= '0;
      dst       <= '0;
      cnt       <= '0;
      go        <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      cfg       <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (upd) begin
        src <= src_nxt;
        dst <= dst_nxt;
        cnt <= cnt - 1'b1;
      end
      if (fin) begin
        done <= 1'b1;
        go   <= 1'b0;
      end
      if (fault) begin
        err <= 1'b1;
        go  <= 1'b0;
      end
      if (reg_we && !go) begin
        case (reg_sel)
          2'd0: src <= reg_wdata[AW-1:0];
          2'd1: dst <= reg_wdata[AW-1:0];
          2'd2: cnt <= reg_wdata[CW-1:0];
          default: begin
            cfg.ie    <= reg_wdata[CB_IE];
            cfg.sm    <= amode_t'(reg_wdata[CB_SM +: 2]);
            cfg.dm    <= amode_t'(reg_wdata[CB_DM +: 2]);
            cfg.sz    <= usize_t'(reg_wdata[CB_SZ +: 2]);
            cfg.burst <= reg_wdata[CB_BURST];
            if (reg_wdata[CB_DONE]) done <= 1'b0;
            if (reg_wdata[CB_ERR])  err  <= 1'b0;
            go <= reg_wdata[CB_GO] & ~done & ~err;
          end
        endcase
      end
      irq <= done & cfg.ie;
      case (reg_sel)
        2'd0:    reg_rdata <= 32'(src);
        2'd1:    reg_rdata <= 32'(dst);
        2'd2:    reg_rdata <= 32'(cnt);
        default: reg_rdata <= ctrl_rd;
      endcase
    end
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  usize_t        sz,
  input  logic          burst,
  input  logic          m_gnt,
  input  logic          m_ack,
  input  logic [31:0]   m_rdata,
  output logic          m_req,
  output logic          m_stb,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  output logic          upd,
  output logic          fin,
  output logic          fault
);
  st_t           st;
  logic [1:0]    beat;
  logic [31:0]   dbuf;
  logic          last_beat;
  logic          misalign;
  logic          last_unit;
  logic [AW-1:0] off;

  assign last_beat = (sz != SZ_QUAD) || (beat == 2'd3);
  assign last_unit = (cnt == CW'(1));
  assign off       = (sz == SZ_QUAD) ? AW'({beat, 2'b00}) : '0;

  always_comb begin
    case (sz)
      SZ_WORD: misalign = src[0] | dst[0];
      SZ_LONG: misalign = (|src[1:0]) | (|dst[1:0]);
      SZ_QUAD: misalign = (|src[3:0]) | (|dst[3:0]);
      default: misalign = 1'b0;
    endcase
  end

  assign fault = (st == ST_IDLE) && go && misalign;
  assign upd   = (st == ST_WR) && m_ack && last_beat;
  assign fin   = ((st == ST_IDLE) && go && !misalign && (cnt == '0)) || (upd && last_unit);

  assign m_req   = (st == ST_REQ) || (st == ST_RD) || (st == ST_WR);
  assign m_stb   = (st == ST_RD) || (st == ST_WR);
  assign m_we    = (st == ST_WR);
  assign m_addr  = ((st == ST_WR) ? dst : src) + off;
  assign m_size  = sz;
  assign m_wdata = dbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      beat <= '0;
      dbuf <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          beat <= '0;
          if (go && !misalign && (cnt != '0)) st <= ST_REQ;
        end
        ST_REQ: if (m_gnt) st <= ST_RD;
        ST_RD: if (m_ack) begin
          dbuf <= m_rdata;
          st   <= ST_WR;
        end
        ST_WR: if (m_ack) begin
          if (!last_beat) begin
            beat <= beat + 2'd1;
            st   <= ST_RD;
          end else begin
            beat <= '0;
            if (last_unit)  st <= ST_IDLE;
            else if (burst) st <= ST_RD;
            else            st <= ST_REL;
          end
        end
        ST_REL:  st <= ST_REQ;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          m_req,
  input  logic          m_gnt,
  output logic          m_stb,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  input  logic          m_ack
);
  localparam int NSIDE = 2;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          go, done, err, upd, fin, fault;
  cfg_t          cfg;
  logic [AW-1:0] cur [NSIDE];
  logic [AW-1:0] nxt [NSIDE];
  amode_t        md  [NSIDE];

  assign cur[0] = src;
  assign cur[1] = dst;
  assign md[0]  = cfg.sm;
  assign md[1]  = cfg.dm;

  for (genvar i = 0; i < NSIDE; i++) begin : g_step
    dma_step #(.AW(AW)) u_step (
      .addr (cur[i]),
      .mode (md[i]),
      .sz   (cfg.sz),
      .nxt  (nxt[i])
    );
  end

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk, .rst, .reg_sel, .reg_we, .reg_wdata, .reg_rdata,
    .upd, .src_nxt(nxt[0]), .dst_nxt(nxt[1]), .fin, .fault,
    .src, .dst, .cnt, .go, .done, .err, .cfg, .irq
  );

  dma_fsm #(.AW(AW), .CW(CW)) u_fsm (
    .clk, .rst, .go, .cnt, .src, .dst, .sz(cfg.sz), .burst(cfg.burst),
    .m_gnt, .m_ack, .m_rdata, .m_req, .m_stb, .m_we, .m_addr, .m_size,
    .m_wdata, .upd, .fin, .fault
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          m_req,
  input logic          m_gnt,
  input logic          m_stb,
  input logic          go,
  input logic          done,
  input logic          err,
  input logic          upd,
  input logic          burst,
  input logic [CW-1:0] cnt
);
  // R9
  stb_grant_chk: assert property (@(posedge clk) disable iff (rst) m_stb |-> m_gnt);

  // R9
  stb_busy_chk: assert property (@(posedge clk) disable iff (rst) m_stb |-> go);

  // R5
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> cnt == $past(cnt) - 1'b1);

  // R8
  steal_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !burst) |=> !m_req);

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && burst && cnt != CW'(1)) |=> m_req);

  // R2
  go_flag_chk: assert property (@(posedge clk) disable iff (rst) go |-> !done && !err);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> !m_req);
endmodule

bind dma_chan dma_chan_chk #(.CW(CW)) u_chk (
  .clk, .rst, .m_req, .m_gnt, .m_stb, .go, .done, .err, .upd,
  .burst(cfg.burst), .cnt
);

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;
  localparam int AW = 16;
  localparam int CW = 8;

  typedef struct packed {
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  cnt;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [1:0]  sz;
    logic        burst;
    logic        ie;
    logic        experr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 16'h0200, 8'd3, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0},
    '{16'h0102, 16'h0340, 8'd4, 2'd2, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0},
    '{16'h0400, 16'h0500, 8'd2, 2'd0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0},
    '{16'h0600, 16'h0700, 8'd2, 2'd2, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0},
    '{16'h0610, 16'h0720, 8'd3, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0},
    '{16'h0103, 16'h0200, 8'd2, 2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1},
    '{16'h0400, 16'h0506, 8'd1, 2'd1, 2'd1, 2'd2, 1'b1, 1'b1, 1'b1},
    '{16'h0800, 16'h0900, 8'd0, 2'd1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0},
    '{16'h0003, 16'h0002, 8'd5, 2'd1, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_sel = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq, m_req, m_stb, m_we;
  logic          m_gnt, m_ack;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;
  logic [31:0]   m_wdata, m_rdata;

  int checks = 0;
  int errors = 0;

  logic [15:0] e_src, e_dst;
  logic [1:0]  e_sm, e_dm, e_sz;
  int          wr_cnt, fall_cnt, rise_cnt;
  logic        prev_req = 1'b0;

  always #4 clk = ~clk;

  dma_chan #(.AW(AW), .CW(CW)) u0 (
    .clk, .rst, .reg_sel, .reg_we, .reg_wdata, .reg_rdata, .irq,
    .m_req, .m_gnt, .m_stb, .m_we, .m_addr, .m_size, .m_wdata, .m_rdata, .m_ack
  );

  function automatic logic [31:0] mem_f(logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [15:0] stepv(logic [15:0] a, logic [1:0] m, logic [1:0] sz, int n);
    logic [15:0] s;
    s = 16'(1 << sz);
    if (sz == 2'd3) return a + 16'(16 * n);
    case (m)
      2'd1:    return a + 16'(n) * s;
      2'd2:    return a - 16'(n) * s;
      default: return a;
    endcase
  endfunction

  assign m_rdata = mem_f(m_addr);

  always @(posedge clk) begin
    if (rst) begin
      m_ack <= 1'b0;
      m_gnt <= 1'b0;
    end else begin
      m_ack <= m_stb & ~m_ack;
      m_gnt <= m_req;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (m_req && !prev_req) rise_cnt++;
      if (!m_req && prev_req) fall_cnt++;
      prev_req = m_req;
      if (m_stb && !m_gnt) chk("R9 strobe without grant", 32'(m_stb), 32'd0);
      if (m_stb && m_we && m_ack) begin
        int beats, u, b;
        beats = (e_sz == 2'd3) ? 4 : 1;
        u = wr_cnt / beats;
        b = wr_cnt % beats;
        // R4 beat offsets, R3 steps
        chk("R3/R4 write address", 32'(m_addr),
            32'(stepv(e_dst, e_dm, e_sz, u) + 16'(4 * b * (beats / 4))));
        chk("R9 write data", m_wdata,
            mem_f(stepv(e_src, e_sm, e_sz, u) + 16'(4 * b * (beats / 4))));
        wr_cnt++;
      end
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(vec_t v, logic g);
    return {21'b0, v.burst, v.sz, v.dm, v.sm, v.ie, 2'b00, g};
  endfunction

  task automatic wait_end();
    logic [31:0] r;
    for (int k = 0; k < 3000; k++) begin
      reg_read(2'd3, r);
      if (r[1] || r[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic arm(input vec_t v);
    reg_write(2'd3, 32'h6);
    reg_write(2'd0, 32'(v.src));
    reg_write(2'd1, 32'(v.dst));
    reg_write(2'd2, 32'(v.cnt));
    e_src = v.src; e_dst = v.dst; e_sm = v.sm; e_dm = v.dm; e_sz = v.sz;
    wr_cnt = 0; fall_cnt = 0; rise_cnt = 0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] r;
    int beats, n;
    arm(v);
    reg_write(2'd3, ctrl_word(v, 1'b1));
    wait_end();
    beats = (v.sz == 2'd3) ? 4 : 1;
    n = v.experr ? 0 : int'(v.cnt);
    reg_read(2'd3, r);
    chk("R5 done flag", 32'(r[1]), 32'(!v.experr));
    chk("R6 error flag", 32'(r[2]), 32'(v.experr));
    chk("R5 start cleared", 32'(r[0]), 32'd0);
    reg_read(2'd2, r);
    chk("R5 final count", r, v.experr ? 32'(v.cnt) : 32'd0);
    reg_read(2'd0, r);
    chk("R3 final source", r, 32'(stepv(v.src, v.sm, v.sz, n)));
    reg_read(2'd1, r);
    chk("R3 final destination", r, 32'(stepv(v.dst, v.dm, v.sz, n)));
    chk("R5 write count", 32'(wr_cnt), 32'(n * beats));
    chk("R7 irq", 32'(irq), 32'(v.ie & !v.experr));
    chk("R8 release count", 32'(fall_cnt),
        (n == 0) ? 32'd0 : (v.burst ? 32'd1 : 32'(n)));
  endtask

  initial begin
    logic [31:0] r;
    e_src = '0; e_dst = '0; e_sm = '0; e_dm = '0; e_sz = '0;
    wr_cnt = 0; fall_cnt = 0; rise_cnt = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 m_req after reset", 32'(m_req), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), r);
      chk("R1 register reset value", r, 32'd0);
    end
    // table of transfers
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 writes during a running transfer are ignored
    arm('{16'h0100, 16'h0200, 8'd6, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0});
    reg_write(2'd3, ctrl_word('{16'h0100, 16'h0200, 8'd6, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0}, 1'b1));
    reg_write(2'd0, 32'h0000_FFF0);
    reg_write(2'd2, 32'd1);
    wait_end();
    reg_read(2'd0, r);
    chk("R10 source after busy write", r, 32'h0106);
    reg_read(2'd2, r);
    chk("R10 count after busy write", r, 32'd0);
    chk("R10 writes made", 32'(wr_cnt), 32'd6);

    // R2 start ignored while done is set
    rise_cnt = 0;
    reg_write(2'd2, 32'd2);
    reg_write(2'd3, 32'h0000_0019);
    repeat (10) @(negedge clk);
    chk("R2 no request while done", 32'(rise_cnt), 32'd0);
    reg_read(2'd3, r);
    chk("R2 start bit stays 0", 32'(r[0]), 32'd0);
    chk("R2 done still set", 32'(r[1]), 32'd1);
    reg_read(2'd2, r);
    chk("R2 count written while idle", r, 32'd2);
    reg_write(2'd3, 32'h0000_0002);
    reg_read(2'd3, r);
    chk("R2 done cleared by write of one", r, 32'd0);
    chk("R7 irq low after clear", 32'(irq), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule